// File: doc/BRIEF.md
# Ethernet DMA control register file

This block is the 32-bit control and status register space of a multi-ring Ethernet DMA engine. Software reaches it through a simple word-aligned read/write bus. Writes take effect on the rising clock edge. Reads are combinational from the addressed register. The block holds an interrupt event register and an interrupt mask register, and it combines the two into three interrupt lines: transmit, receive and error. The DMA side can raise event bits through a set vector.

Each of the eight transmit rings and eight receive rings has a halt flag in a per-direction status register. When software clears a halt flag, that write also starts the ring again: the block sends a one-cycle restart pulse to the ring's descriptor walker. Each ring also has a base address register and a live descriptor pointer. A write to a base register aligns the value to eight bytes and loads the pointer with it. After that, the DMA walker advances the pointer through its own update port.

A bank of generic registers completes the space. A parameter table gives each of them an access type: read/write, read-only, write-only or write-one-to-clear.

Top module: `eth_dma_regfile`

## Requirements
- R1: The event register (byte offset 0x00) is write-one-to-clear from the bus. In the same cycle, each bit of `evt_set` ORs a 1 into the event register. A set wins over a clear that hits the same bit.
- R2: The mask register (offset 0x04) is read/write. `irq_tx`, `irq_rx` and `irq_err` are each the OR of (event AND mask AND group). The default groups are 0x000000FF for transmit, 0x0000FF00 for receive and 0xFFFF0000 for error. The outputs follow any change of event or mask in the cycle after the clock edge.
- R3: In the transmit status register (offset 0x08), bit 31-i is the halt flag of transmit ring i. Writing 1 to that bit clears the flag. It also drives `tx_restart[i]` high for exactly the one cycle after the write edge, whether or not the flag was set.
- R4: In the receive status register (offset 0x0C), bit 23-i is the halt flag of receive ring i. The register is write-one-to-clear. `rx_restart[i]` pulses for one cycle only when a 1 is written to a flag that reads 0 before the write.
- R5: A pulse on `tx_halt_set[i]` or `rx_halt_set[i]` sets ring i's halt flag. A set wins over a bus clear in the same cycle. Status bits that are not halt flags always read 0.
- R6: A write to transmit base n (offset 0x20+4n) or receive base n (offset 0x60+4n) stores the data with bits [2:0] forced to 0. It also loads that same value into the ring's pointer: transmit pointer n at 0x40+4n, receive pointer n at 0x80+4n.
- R7: The pointer registers are read/write from the bus. A DMA-side update (`*_upd_en`, `*_upd_ring`, `*_upd_val`) to the same ring in the same cycle wins over a bus pointer write or base write. Updates to other rings do not block a bus write.
- R8: Generic register g sits at offset 0xA0+4g, with access type g mod 4 in the default table (0 RW, 1 RO, 2 WO, 3 W1C). RW and WO take the write data. W1C clears the written ones. RO ignores writes. WO reads as 0, and the others read their stored value.
- R9: After reset, generic register g holds (g+1)×0x11111111 and all other registers hold 0. Offsets that are not listed read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address, bits [1:0] ignored |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr |
| evt_set | input | DW | DMA-side event set bits |
| tx_halt_set | input | NUM_RINGS | Sets transmit ring halt flags |
| rx_halt_set | input | NUM_RINGS | Sets receive ring halt flags |
| tx_upd_en | input | 1 | Transmit pointer update strobe |
| tx_upd_ring | input | RIDX_W | Transmit ring being updated |
| tx_upd_val | input | DW | New transmit pointer value |
| rx_upd_en | input | 1 | Receive pointer update strobe |
| rx_upd_ring | input | RIDX_W | Receive ring being updated |
| rx_upd_val | input | DW | New receive pointer value |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |
| tx_restart | output | NUM_RINGS | One-cycle transmit ring restart pulses |
| rx_restart | output | NUM_RINGS | One-cycle receive ring restart pulses |

## Verification
The interrupt path is tested with one event and mask bit at a time across all 32 positions. This confirms that each bit reaches exactly its own group's line, and that a masked event or a cleared bit stays quiet. All 256 clear patterns go to the transmit status register against fully set flags. This separates a correct bit-reversed ring order from a shifted or straight one. The receive register is tested with a 16 by 16 grid of prior-flag and written patterns, which tells its read-zero gate apart from the transmit rule. Base writes use unaligned values on every ring, and the pointer tests include same-cycle collisions with the DMA update. Both kinds of test expose lost alignment, a missing copy or an inverted priority.

// File: rtl/eth_dma_regs_pkg.sv
package eth_dma_regs_pkg;

   typedef enum logic [1:0] {
      ACC_RW  = 2'd0,
      ACC_RO  = 2'd1,
      ACC_WO  = 2'd2,
      ACC_W1C = 2'd3
   } acc_e;

   // word indices (byte offset / 4)
   localparam int unsigned W_EVENT  = 0;
   localparam int unsigned W_MASK   = 1;
   localparam int unsigned W_TXSTAT = 2;
   localparam int unsigned W_RXSTAT = 3;
   localparam int unsigned W_TXBASE = 8;
   localparam int unsigned W_TXPTR  = 16;
   localparam int unsigned W_RXBASE = 24;
   localparam int unsigned W_RXPTR  = 32;
   localparam int unsigned W_GEN    = 40;

   // highest halt flag position in each status word; ring i sits at TOP - i
   localparam int unsigned TX_FLAG_TOP = 31;
   localparam int unsigned RX_FLAG_TOP = 23;

endpackage

// File: rtl/dma_irq_unit.sv
module dma_irq_unit #(
   parameter int unsigned     DW       = 32,
   parameter logic [DW-1:0]   TX_GRP   = '0,
   parameter logic [DW-1:0]   RX_GRP   = '0,
   parameter logic [DW-1:0]   ERR_GRP  = '0,
   parameter logic [DW-1:0]   MASK_RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_wr,
   input  logic          mask_wr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] evt_set,
   output logic [DW-1:0] evt_q,
   output logic [DW-1:0] mask_q,
   output logic          irq_tx,
   output logic          irq_rx,
   output logic          irq_err
);
   logic [DW-1:0] clr;
   logic [DW-1:0] active;

   assign clr = evt_wr ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q  <= '0;
         mask_q <= MASK_RST;
      end else begin
         evt_q <= (evt_q & ~clr) | evt_set;
         if (mask_wr) mask_q <= wdata;
      end
   end

   assign active  = evt_q & mask_q;
   assign irq_tx  = |(active & TX_GRP);
   assign irq_rx  = |(active & RX_GRP);
   assign irq_err = |(active & ERR_GRP);
endmodule

// File: rtl/dma_halt_status.sv
module dma_halt_status #(
   parameter int unsigned DW      = 32,
   parameter int unsigned NR      = 8,
   parameter int unsigned TOP_BIT = 31,
   parameter bit          GATE    = 1'b0   // 1: restart only when flag reads 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic [NR-1:0] halt_set,
   output logic [DW-1:0] stat_q,
   output logic [NR-1:0] restart_q
);
   logic [NR-1:0] flag_q;
   logic [NR-1:0] clr;
   logic [NR-1:0] req;
   logic          unused_wdata;

   if (TOP_BIT >= DW || TOP_BIT + 1 < NR) begin : g_bad_top
      $error("dma_halt_status: flag field does not fit the word");
   end

   assign unused_wdata = ^wdata;

   for (genvar i = 0; i < NR; i++) begin : g_ring
      assign clr[i] = wr & wdata[TOP_BIT-i];
      if (GATE) begin : g_gated
         assign req[i] = clr[i] & ~flag_q[i];
      end else begin : g_plain
         assign req[i] = clr[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q    <= '0;
         restart_q <= '0;
      end else begin
         flag_q    <= halt_set | (flag_q & ~clr);
         restart_q <= req;
      end
   end

   always_comb begin
      stat_q = '0;
      for (int i = 0; i < int'(NR); i++) stat_q[TOP_BIT-i] = flag_q[i];
   end
endmodule

// File: rtl/dma_ring_ptrs.sv
module dma_ring_ptrs #(
   parameter int unsigned DW     = 32,
   parameter int unsigned NR     = 8,
   parameter int unsigned ALIGN  = 3,
   parameter int unsigned RIDX_W = (NR > 1) ? $clog2(NR) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NR-1:0]    base_wr,
   input  logic [NR-1:0]    ptr_wr,
   input  logic [DW-1:0]    wdata,
   input  logic             upd_en,
   input  logic [RIDX_W-1:0] upd_ring,
   input  logic [DW-1:0]    upd_val,
   output logic [NR*DW-1:0] base_flat,
   output logic [NR*DW-1:0] ptr_flat
);
   logic [DW-1:0] aligned;

   assign aligned = {wdata[DW-1:ALIGN], {ALIGN{1'b0}}};

   for (genvar n = 0; n < NR; n++) begin : g_ring
      logic hit;
      assign hit = upd_en && (upd_ring == RIDX_W'(n));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_flat[n*DW +: DW] <= '0;
            ptr_flat[n*DW +: DW]  <= '0;
         end else begin
            if (base_wr[n]) base_flat[n*DW +: DW] <= aligned;
            if (hit)             ptr_flat[n*DW +: DW] <= upd_val;
            else if (base_wr[n]) ptr_flat[n*DW +: DW] <= aligned;
            else if (ptr_wr[n])  ptr_flat[n*DW +: DW] <= wdata;
         end
      end
   end
endmodule

// File: rtl/dma_generic_regs.sv
module dma_generic_regs
   import eth_dma_regs_pkg::*;
#(
   parameter int unsigned          DW        = 32,
   parameter int unsigned          NG        = 8,
   parameter logic [2*NG-1:0]      ACC_TABLE = '0,
   parameter logic [DW*NG-1:0]     RST_TABLE = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NG-1:0]    wr,
   input  logic [DW-1:0]    wdata,
   output logic [NG*DW-1:0] rd_flat
);
   logic unused_in;
   assign unused_in = ^{wr, wdata};

   for (genvar g = 0; g < NG; g++) begin : g_reg
      localparam acc_e          ACC = acc_e'(ACC_TABLE[2*g +: 2]);
      localparam logic [DW-1:0] RST = RST_TABLE[g*DW +: DW];
      logic [DW-1:0] q;

      if (ACC == ACC_RO) begin : g_ro
         assign q = RST;
      end else begin : g_stored
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= RST;
            else if (wr[g]) q <= (ACC == ACC_W1C) ? (q & ~wdata) : wdata;
         end
      end

      if (ACC == ACC_WO) begin : g_hide
         assign rd_flat[g*DW +: DW] = '0;
      end else begin : g_show
         assign rd_flat[g*DW +: DW] = q;
      end
   end
endmodule

// File: rtl/eth_dma_regfile.sv
module eth_dma_regfile
   import eth_dma_regs_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DW        = 32,
   parameter int unsigned       NUM_RINGS = 8,
   parameter int unsigned       NUM_GEN   = 8,
   parameter logic [DW-1:0]     TX_GRP    = 32'h0000_00FF,
   parameter logic [DW-1:0]     RX_GRP    = 32'h0000_FF00,
   parameter logic [DW-1:0]     ERR_GRP   = 32'hFFFF_0000,
   parameter logic [DW-1:0]     MASK_RST  = '0,
   parameter logic [2*NUM_GEN-1:0]  GEN_ACC = 16'hE4E4,
   parameter logic [DW*NUM_GEN-1:0] GEN_RST = {32'h8888_8888, 32'h7777_7777,
                                               32'h6666_6666, 32'h5555_5555,
                                               32'h4444_4444, 32'h3333_3333,
                                               32'h2222_2222, 32'h1111_1111},
   localparam int unsigned      RIDX_W    = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [DW-1:0]        bus_wdata,
   output logic [DW-1:0]        bus_rdata,
   input  logic [DW-1:0]        evt_set,
   input  logic [NUM_RINGS-1:0] tx_halt_set,
   input  logic [NUM_RINGS-1:0] rx_halt_set,
   input  logic                 tx_upd_en,
   input  logic [RIDX_W-1:0]    tx_upd_ring,
   input  logic [DW-1:0]        tx_upd_val,
   input  logic                 rx_upd_en,
   input  logic [RIDX_W-1:0]    rx_upd_ring,
   input  logic [DW-1:0]        rx_upd_val,
   output logic                 irq_tx,
   output logic                 irq_rx,
   output logic                 irq_err,
   output logic [NUM_RINGS-1:0] tx_restart,
   output logic [NUM_RINGS-1:0] rx_restart
);
   localparam int unsigned WA_W = ADDR_W - 2;

   if (DW != 32) begin : g_bad_dw
      $error("eth_dma_regfile: status layout needs 32-bit words");
   end
   if (NUM_RINGS < 1 || NUM_RINGS > 8) begin : g_bad_rings
      $error("eth_dma_regfile: NUM_RINGS must be 1..8");
   end
   if (W_GEN + NUM_GEN > (1 << WA_W)) begin : g_bad_addr
      $error("eth_dma_regfile: ADDR_W too small for the map");
   end

   logic [WA_W-1:0]          word;
   logic                     unused_lsb;
   logic [DW-1:0]            evt_q, mask_q, tx_stat_q, rx_stat_q;
   logic [NUM_RINGS-1:0]     tx_base_wr, tx_ptr_wr, rx_base_wr, rx_ptr_wr;
   logic [NUM_RINGS*DW-1:0]  tx_base_flat, tx_ptr_flat, rx_base_flat, rx_ptr_flat;
   logic [NUM_GEN-1:0]       gen_wr;
   logic [NUM_GEN*DW-1:0]    gen_rd_flat;

   assign word       = bus_addr[ADDR_W-1:2];
   assign unused_lsb = ^bus_addr[1:0];

   for (genvar n = 0; n < NUM_RINGS; n++) begin : g_dec
      assign tx_base_wr[n] = bus_wr && (word == WA_W'(W_TXBASE + n));
      assign tx_ptr_wr[n]  = bus_wr && (word == WA_W'(W_TXPTR + n));
      assign rx_base_wr[n] = bus_wr && (word == WA_W'(W_RXBASE + n));
      assign rx_ptr_wr[n]  = bus_wr && (word == WA_W'(W_RXPTR + n));
   end
   for (genvar g = 0; g < NUM_GEN; g++) begin : g_gdec
      assign gen_wr[g] = bus_wr && (word == WA_W'(W_GEN + g));
   end

   dma_irq_unit #(.DW(DW), .TX_GRP(TX_GRP), .RX_GRP(RX_GRP),
                  .ERR_GRP(ERR_GRP), .MASK_RST(MASK_RST)) u_irq (
      .clk, .rst_n,
      .evt_wr (bus_wr && (word == WA_W'(W_EVENT))),
      .mask_wr(bus_wr && (word == WA_W'(W_MASK))),
      .wdata  (bus_wdata),
      .evt_set,
      .evt_q, .mask_q, .irq_tx, .irq_rx, .irq_err
   );

   dma_halt_status #(.DW(DW), .NR(NUM_RINGS), .TOP_BIT(TX_FLAG_TOP), .GATE(1'b0)) u_tx_halt (
      .clk, .rst_n,
      .wr(bus_wr && (word == WA_W'(W_TXSTAT))), .wdata(bus_wdata),
      .halt_set(tx_halt_set), .stat_q(tx_stat_q), .restart_q(tx_restart)
   );

   dma_halt_status #(.DW(DW), .NR(NUM_RINGS), .TOP_BIT(RX_FLAG_TOP), .GATE(1'b1)) u_rx_halt (
      .clk, .rst_n,
      .wr(bus_wr && (word == WA_W'(W_RXSTAT))), .wdata(bus_wdata),
      .halt_set(rx_halt_set), .stat_q(rx_stat_q), .restart_q(rx_restart)
   );

   dma_ring_ptrs #(.DW(DW), .NR(NUM_RINGS), .RIDX_W(RIDX_W)) u_tx_ring (
      .clk, .rst_n, .base_wr(tx_base_wr), .ptr_wr(tx_ptr_wr), .wdata(bus_wdata),
      .upd_en(tx_upd_en), .upd_ring(tx_upd_ring), .upd_val(tx_upd_val),
      .base_flat(tx_base_flat), .ptr_flat(tx_ptr_flat)
   );

   dma_ring_ptrs #(.DW(DW), .NR(NUM_RINGS), .RIDX_W(RIDX_W)) u_rx_ring (
      .clk, .rst_n, .base_wr(rx_base_wr), .ptr_wr(rx_ptr_wr), .wdata(bus_wdata),
      .upd_en(rx_upd_en), .upd_ring(rx_upd_ring), .upd_val(rx_upd_val),
      .base_flat(rx_base_flat), .ptr_flat(rx_ptr_flat)
   );

   dma_generic_regs #(.DW(DW), .NG(NUM_GEN), .ACC_TABLE(GEN_ACC), .RST_TABLE(GEN_RST)) u_gen (
      .clk, .rst_n, .wr(gen_wr), .wdata(bus_wdata), .rd_flat(gen_rd_flat)
   );

   always_comb begin
      bus_rdata = '0;
      if (word == WA_W'(W_EVENT))  bus_rdata = evt_q;
      if (word == WA_W'(W_MASK))   bus_rdata = mask_q;
      if (word == WA_W'(W_TXSTAT)) bus_rdata = tx_stat_q;
      if (word == WA_W'(W_RXSTAT)) bus_rdata = rx_stat_q;
      for (int i = 0; i < int'(NUM_RINGS); i++) begin
         if (word == WA_W'(W_TXBASE + i)) bus_rdata = tx_base_flat[i*DW +: DW];
         if (word == WA_W'(W_TXPTR + i))  bus_rdata = tx_ptr_flat[i*DW +: DW];
         if (word == WA_W'(W_RXBASE + i)) bus_rdata = rx_base_flat[i*DW +: DW];
         if (word == WA_W'(W_RXPTR + i))  bus_rdata = rx_ptr_flat[i*DW +: DW];
      end
      for (int g = 0; g < int'(NUM_GEN); g++) begin
         if (word == WA_W'(W_GEN + g)) bus_rdata = gen_rd_flat[g*DW +: DW];
      end
   end
endmodule

// File: rtl/dma_regfile_checker.sv
module dma_regfile_checker
   import eth_dma_regs_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DW      = 32,
   parameter int unsigned NR      = 8,
   parameter int unsigned NG      = 8,
   parameter int unsigned RIDX_W  = 3,
   parameter logic [2*NG-1:0] ACC_TABLE = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DW-1:0]     bus_wdata,
   input logic [DW-1:0]     bus_rdata,
   input logic [DW-1:0]     evt_set,
   input logic [DW-1:0]     evt_q,
   input logic [DW-1:0]     rx_stat_q,
   input logic [NR*DW-1:0]  tx_ptr_flat,
   input logic              tx_upd_en,
   input logic [RIDX_W-1:0] tx_upd_ring,
   input logic [DW-1:0]     tx_upd_val,
   input logic [NR-1:0]     tx_restart,
   input logic [NR-1:0]     rx_restart
);
   localparam int unsigned WA_W = ADDR_W - 2;
   logic [WA_W-1:0] word;
   assign word = bus_addr[ADDR_W-1:2];

   function automatic logic [NR-1:0] flags_of(input logic [DW-1:0] v, input int top);
      logic [NR-1:0] f;
      for (int i = 0; i < int'(NR); i++) f[i] = v[top-i];
      return f;
   endfunction

   // R1: every set bit lands in the event register
   p_evt_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set != '0) |=> ((evt_q & $past(evt_set)) == $past(evt_set)));

   // R3: transmit restarts mirror the written flag bits, bit-reversed
   p_tx_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && word == WA_W'(W_TXSTAT)) |=> (tx_restart == flags_of($past(bus_wdata), TX_FLAG_TOP)));

   // R3: no transmit restart without a status write
   p_tx_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && word == WA_W'(W_TXSTAT)) |=> (tx_restart == '0));

   // R4: a receive restart never fires for a flag that was set
   p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && word == WA_W'(W_RXSTAT)) |=>
         ((rx_restart & flags_of($past(rx_stat_q), RX_FLAG_TOP)) == '0));

   // R4: no receive restart without a status write
   p_rx_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && word == WA_W'(W_RXSTAT)) |=> (rx_restart == '0));

   // R6: base write of ring 0 loads the aligned value into its pointer
   p_base_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && word == WA_W'(W_TXBASE) && !(tx_upd_en && tx_upd_ring == '0)) |=>
         (tx_ptr_flat[DW-1:0] == {$past(bus_wdata[DW-1:3]), 3'b000}));

   // R7: a DMA update of ring 0 always lands
   p_upd_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_upd_en && tx_upd_ring == '0) |=> (tx_ptr_flat[DW-1:0] == $past(tx_upd_val)));

   // R8: write-only generic registers read as zero
   for (genvar g = 0; g < NG; g++) begin : g_wo
      if (acc_e'(ACC_TABLE[2*g +: 2]) == ACC_WO) begin : g_chk
         p_wo_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (word == WA_W'(W_GEN + g)) |-> (bus_rdata == '0));
      end
   end
endmodule

bind eth_dma_regfile dma_regfile_checker #(
   .ADDR_W(ADDR_W), .DW(DW), .NR(NUM_RINGS), .NG(NUM_GEN),
   .RIDX_W(RIDX_W), .ACC_TABLE(GEN_ACC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
   .evt_q(evt_q), .rx_stat_q(rx_stat_q), .tx_ptr_flat(tx_ptr_flat),
   .tx_upd_en(tx_upd_en), .tx_upd_ring(tx_upd_ring), .tx_upd_val(tx_upd_val),
   .tx_restart(tx_restart), .rx_restart(rx_restart)
);

// File: tb/tb_eth_dma_regfile.sv
`timescale 1ns/1ps
module tb_eth_dma_regfile;
   localparam int NR = 8;
   localparam logic [31:0] TXG = 32'h0000_00FF;
   localparam logic [31:0] RXG = 32'h0000_FF00;
   localparam logic [31:0] ERG = 32'hFFFF_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] evt_set = '0;
   logic [7:0]  tx_halt_set = '0, rx_halt_set = '0;
   logic        tx_upd_en = 1'b0, rx_upd_en = 1'b0;
   logic [2:0]  tx_upd_ring = '0, rx_upd_ring = '0;
   logic [31:0] tx_upd_val = '0, rx_upd_val = '0;
   logic        irq_tx, irq_rx, irq_err;
   logic [7:0]  tx_restart, rx_restart;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] tx_rs, rx_rs;

   always #2 clk = ~clk;

   eth_dma_regfile dut (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int word, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 8'(word * 4); bus_wr = 1'b1; bus_wdata = d;
      @(posedge clk); #1;
      tx_rs = tx_restart; rx_rs = rx_restart;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int word, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 8'(word * 4); bus_wr = 1'b0;
      #1 d = bus_rdata;
   endtask

   function automatic logic [31:0] place(input logic [7:0] p, input int top);
      logic [31:0] v = '0;
      for (int i = 0; i < NR; i++) v[top-i] = p[i];
      return v;
   endfunction

   function automatic logic [31:0] rst_val(input int w);
      if (w == 1) return 32'h0;
      if (w >= 40 && w < 48) return ((w - 40) % 4 == 2) ? 32'h0 : 32'(w - 39) * 32'h1111_1111;
      return 32'h0;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d, v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R9: reset image over the whole address space
      for (int w = 0; w < 64; w++) begin
         rd(w, d);
         check($sformatf("R9 reset word %0d", w), d, rst_val(w));
      end
      check("R2 irq idle", {29'b0, irq_tx, irq_rx, irq_err}, 32'h0);

      // R1/R2: walk one event and mask bit through all positions
      for (int b = 0; b < 32; b++) begin
         v = 32'h1 << b;
         @(negedge clk) evt_set = v;
         @(negedge clk) evt_set = '0;
         check("R2 masked event quiet", {29'b0, irq_tx, irq_rx, irq_err}, 32'h0);
         wr(1, v);
         rd(1, d); check("R2 mask readback", d, v);
         rd(0, d); check("R1 event set", d, v);
         check($sformatf("R2 groups bit %0d", b), {29'b0, irq_tx, irq_rx, irq_err},
               {29'b0, |(v & TXG), |(v & RXG), |(v & ERG)});
         wr(0, v);
         rd(0, d); check("R1 event w1c", d, 32'h0);
         check("R2 irq after clear", {29'b0, irq_tx, irq_rx, irq_err}, 32'h0);
      end

      // R1: set wins over a same-cycle clear
      @(negedge clk) evt_set = 32'h40;
      @(negedge clk) begin
         evt_set = 32'h20; bus_addr = 8'h00; bus_wr = 1'b1; bus_wdata = 32'h60;
      end
      @(negedge clk) begin evt_set = '0; bus_wr = 1'b0; end
      rd(0, d); check("R1 set beats clear", d, 32'h20);
      wr(0, 32'hFFFF_FFFF);

      // R3/R5: every transmit clear pattern against all flags set
      for (int p = 0; p < 256; p++) begin
         @(negedge clk) tx_halt_set = 8'hFF;
         @(negedge clk) tx_halt_set = 8'h00;
         wr(2, place(8'(p), 31));
         check($sformatf("R3 tx restart pattern %0d", p), {24'b0, tx_rs}, 32'(p));
         rd(2, d); check("R3 tx flags after clear", d, place(~8'(p), 31));
         @(posedge clk) #1 check("R3 tx pulse one cycle", {24'b0, tx_restart}, 32'h0);
      end
      wr(2, 32'hFFFF_FFFF);
      check("R3 tx restart with flags clear", {24'b0, tx_rs}, 32'hFF);
      rd(2, d); check("R5 tx non-flag bits zero", d, 32'h0);

      // R5: halt set beats bus clear in the same cycle
      @(negedge clk) begin
         tx_halt_set = 8'h01; bus_addr = 8'h08; bus_wr = 1'b1; bus_wdata = 32'h8000_0000;
      end
      @(negedge clk) begin tx_halt_set = '0; bus_wr = 1'b0; end
      rd(2, d); check("R5 set beats clear", d, 32'h8000_0000);

      // R4: receive gate over prior-state by written grid
      for (int si = 0; si < 16; si++) begin
         for (int wj = 0; wj < 16; wj++) begin
            logic [7:0] s, w;
            s = 8'(si * 17); w = 8'(wj * 17);
            wr(3, 32'hFFFF_FFFF);
            @(negedge clk) rx_halt_set = s;
            @(negedge clk) rx_halt_set = 8'h00;
            wr(3, place(w, 23));
            check($sformatf("R4 rx restart s=%h w=%h", s, w), {24'b0, rx_rs}, {24'b0, w & ~s});
            rd(3, d); check("R4 rx flags w1c", d, place(s & ~w, 23));
         end
      end

      // R6: unaligned base writes on every ring
      for (int n = 0; n < NR; n++) begin
         v = 32'hDEAD_BEEF ^ (32'(n) * 32'h0101_0105);
         wr(8 + n, v);
         rd(8 + n, d);  check("R6 tx base aligned", d, v & ~32'h7);
         rd(16 + n, d); check("R6 tx ptr copied", d, v & ~32'h7);
         wr(24 + n, ~v);
         rd(24 + n, d); check("R6 rx base aligned", d, ~v & ~32'h7);
         rd(32 + n, d); check("R6 rx ptr copied", d, ~v & ~32'h7);
      end

      // R7: pointer bus writes and DMA priority
      for (int n = 0; n < NR; n++) begin
         wr(16 + n, 32'h1234_5670 + 32'(n));
         rd(16 + n, d); check("R7 tx ptr bus write", d, 32'h1234_5670 + 32'(n));
         @(negedge clk) begin
            bus_addr = 8'((16 + n) * 4); bus_wr = 1'b1; bus_wdata = 32'hAAAA_0000;
            tx_upd_en = 1'b1; tx_upd_ring = 3'(n); tx_upd_val = 32'h5555_0000 + 32'(n);
            rx_upd_en = 1'b1; rx_upd_ring = 3'(n); rx_upd_val = 32'h6666_0000 + 32'(n);
         end
         @(negedge clk) begin
            bus_addr = 8'((32 + n) * 4); bus_wdata = 32'hBBBB_0000;
            tx_upd_en = 1'b0;
            rx_upd_ring = 3'(n + 1); rx_upd_val = 32'h7777_0000;
         end
         @(negedge clk) begin bus_wr = 1'b0; rx_upd_en = 1'b0; end
         rd(16 + n, d); check("R7 tx update wins", d, 32'h5555_0000 + 32'(n));
         rd(32 + n, d); check("R7 rx other-ring update leaves bus write", d, 32'hBBBB_0000);
         rd(32 + ((n + 1) % NR), d); check("R7 rx other ring updated", d, 32'h7777_0000);
      end

      // R8: generic access types
      for (int g = 0; g < 8; g++) begin
         logic [31:0] rv, e;
         rv = 32'(g + 1) * 32'h1111_1111;
         v  = 32'hF0F0_3C3C ^ 32'(g);
         wr(40 + g, v);
         rd(40 + g, d);
         case (g % 4)
            0: e = v;
            1: e = rv;
            2: e = 32'h0;
            default: e = rv & ~v;
         endcase
         check($sformatf("R8 generic %0d type %0d", g, g % 4), d, e);
      end

      // R9: unlisted offsets ignore writes
      wr(4, 32'hFFFF_FFFF); rd(4, d);   check("R9 unlisted word 4", d, 32'h0);
      wr(50, 32'hFFFF_FFFF); rd(50, d); check("R9 unlisted word 50", d, 32'h0);
      rd(1, d); check("R9 unlisted write leaves mask", d, 32'h8000_0000);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule